// File: doc/BRIEF.md
# Three-Wire Wiper Position Controller

This block is the digital half of a 100-step resistor divider. Three asynchronous pins drive it: an active-low select, a step strobe and a direction level. Each pin passes through a synchroniser into the system clock domain. A falling edge on the step strobe while the block is selected moves a wiper position counter by one place. The counter stops at both ends and does not wrap. The position is decoded onto a one-hot bus with one line per tap.

A register stands in for the non-volatile cell. Its content is kept across reset, and reset loads the wiper counter from it, which models recall at power-up. When the select pin is released, the level of the step strobe at that moment decides what happens. If the strobe is high, the position is copied into the register and a busy flag is held for a configurable number of cycles, which represents the programming time. If the strobe is low, the block deselects without storing. In both cases the block then reports standby until it is selected again.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: `position_o` stays within 0..NUM_TAPS-1, and `tap_sel_o` has exactly one bit set: bit number `position_o`.
- R2: The position changes only on a synchronised high-to-low transition of `inc_i` that occurs while `cs_n_i` is low. Strobe edges while `cs_n_i` is high leave the position unchanged.
- R3: `dir_up_i` is sampled at the strobe's falling edge. A 1 adds one to the position and a 0 subtracts one. The direction may be changed between steps while the block stays selected.
- R4: A step up at NUM_TAPS-1 and a step down at 0 leave the position unchanged.
- R5: A rise of `cs_n_i` while `inc_i` is high copies the position into the non-volatile register. `store_busy_o` is then high for exactly STORE_CYCLES cycles, and `store_done_o` pulses for one cycle as busy falls.
- R6: A rise of `cs_n_i` while `inc_i` is low stores nothing. `store_busy_o` stays low, the position is kept, the register keeps its old content, and `standby_o` rises at once.
- R7: `standby_o` is high after reset and after a store completes with `cs_n_i` high. It stays high until `cs_n_i` goes low. It is low while the block is selected and while a store is in progress.
- R8: Reset loads the position from the non-volatile register. The register holds NV_INIT until the first store, and a stored value survives later resets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Synchronous active-low reset (models power-up) |
| cs_n_i | input | 1 | Asynchronous select, active low |
| inc_i | input | 1 | Asynchronous step strobe; acts on its falling edge |
| dir_up_i | input | 1 | Asynchronous direction: 1 up, 0 down |
| tap_sel_o | output | NUM_TAPS (100) | One-hot tap select |
| position_o | output | clog2(NUM_TAPS) (7) | Current wiper position |
| store_busy_o | output | 1 | Store in progress |
| store_done_o | output | 1 | One-cycle pulse when a store finishes |
| standby_o | output | 1 | Block is deselected and idle |

## Verification
The hardest state to reach is proof that the stored value survived. The register is visible only through the position it produces after a reset. The stimulus therefore mixes random stores, no-store releases and walks, and issues a reset at intervals so the bench can compare the recalled position with the last committed value. A no-store release can only occur right after a step, because the strobe must already be low when select rises. The bench combines the two in one sequence.

// File: rtl/wpc_pkg.sv
`timescale 1ns/1ps
package wpc_pkg;

   // Synchronised control pins, MSB first: select, strobe, direction
   typedef struct packed {
      logic cs_n;
      logic inc;
      logic up;
   } pin_set_t;

   localparam logic [2:0] PINS_IDLE = 3'b110;

   typedef enum logic [1:0] {
      SU_ACTIVE  = 2'd0,
      SU_STORING = 2'd1,
      SU_STANDBY = 2'd2
   } store_state_e;

endpackage

// File: rtl/wpc_sync.sv
`timescale 1ns/1ps
module wpc_sync #(
   parameter int unsigned STAGES    = 2,
   parameter int unsigned WIDTH     = 3,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [WIDTH-1:0] din_i,
   output logic [WIDTH-1:0] dout_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("wpc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) stage_q <= {STAGES{RESET_VAL}};
      else          stage_q <= {stage_q[STAGES-2:0], din_i};
   end

   assign dout_o = stage_q[STAGES-1];

endmodule

// File: rtl/wpc_counter.sv
`timescale 1ns/1ps
module wpc_counter #(
   parameter int unsigned NUM_TAPS = 100,
   parameter int unsigned POS_W    = 7
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [POS_W-1:0] load_val_i,
   input  logic             step_i,
   input  logic             up_i,
   output logic [POS_W-1:0] pos_o
);

   localparam logic [POS_W-1:0] TOP = POS_W'(NUM_TAPS - 1);

   logic [POS_W-1:0] pos_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         pos_q <= load_val_i;
      end else if (step_i) begin
         if (up_i) begin
            if (pos_q != TOP) pos_q <= pos_q + 1'b1;
         end else begin
            if (pos_q != '0) pos_q <= pos_q - 1'b1;
         end
      end
   end

   assign pos_o = pos_q;

   AST_POS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      pos_q <= TOP); // R1
   AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !step_i |=> $stable(pos_q)); // R2
   AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      step_i && up_i && pos_q != TOP |=> pos_q == $past(pos_q) + 1'b1); // R3
   AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      step_i && !up_i && pos_q != '0 |=> pos_q == $past(pos_q) - 1'b1); // R3
   AST_SAT_ENDS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      step_i && ((up_i && pos_q == TOP) || (!up_i && pos_q == '0)) |=> $stable(pos_q)); // R4

endmodule

// File: rtl/wpc_decode.sv
`timescale 1ns/1ps
module wpc_decode #(
   parameter int unsigned NUM_TAPS = 100,
   parameter int unsigned POS_W    = 7,
   parameter bit          OUT_REG  = 1'b0
) (
   input  logic                clk_i,
   input  logic [POS_W-1:0]    pos_i,
   output logic [NUM_TAPS-1:0] hot_o
);

   logic [NUM_TAPS-1:0] hot_c;

   for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
      assign hot_c[t] = (pos_i == POS_W'(t));
   end

   if (OUT_REG) begin : g_reg
      logic [NUM_TAPS-1:0] hot_q;
      always_ff @(posedge clk_i) hot_q <= hot_c;
      assign hot_o = hot_q;
   end else begin : g_comb
      assign hot_o = hot_c;
   end

endmodule

// File: rtl/wpc_store.sv
`timescale 1ns/1ps
module wpc_store
   import wpc_pkg::*;
#(
   parameter int unsigned POS_W        = 7,
   parameter int unsigned STORE_CYCLES = 2_500_000,
   parameter int unsigned NV_INIT      = 50
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             cs_n_s_i,
   input  logic             cs_rise_i,
   input  logic             inc_s_i,
   input  logic [POS_W-1:0] pos_i,
   output logic [POS_W-1:0] nv_val_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             standby_o
);

   localparam int unsigned CNT_W = (STORE_CYCLES > 1) ? $clog2(STORE_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STORE_CYCLES - 1);

   logic             store_go;
   store_state_e     state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   // Persistent across reset: stands in for the non-volatile cell
   logic [POS_W-1:0] nv_q = POS_W'(NV_INIT);

   assign store_go = rst_n_i & cs_rise_i & inc_s_i;

   always_ff @(posedge clk_i) begin
      if (store_go) nv_q <= pos_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         state_q <= SU_STANDBY;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (store_go) begin
            state_q <= SU_STORING;
            cnt_q   <= CNT_LOAD;
         end else begin
            unique case (state_q)
               SU_ACTIVE: begin
                  if (cs_rise_i) state_q <= SU_STANDBY;
               end
               SU_STORING: begin
                  if (cnt_q == '0) begin
                     done_q  <= 1'b1;
                     state_q <= cs_n_s_i ? SU_STANDBY : SU_ACTIVE;
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                  end
               end
               SU_STANDBY: begin
                  if (!cs_n_s_i) state_q <= SU_ACTIVE;
               end
               default: state_q <= SU_STANDBY;
            endcase
         end
      end
   end

   assign nv_val_o  = nv_q;
   assign busy_o    = (state_q == SU_STORING);
   assign done_o    = done_q;
   assign standby_o = (state_q == SU_STANDBY);

   AST_NV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !store_go |=> $stable(nv_q)); // R6
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      done_o |-> !busy_o && $past(busy_o)); // R5
   AST_GO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      store_go |=> busy_o && !standby_o); // R5

endmodule

// File: rtl/wiper_pos_ctrl.sv
`timescale 1ns/1ps
module wiper_pos_ctrl
   import wpc_pkg::*;
#(
   parameter int unsigned NUM_TAPS     = 100,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned STORE_CYCLES = 2_500_000,
   parameter int unsigned NV_INIT      = 50,
   parameter bit          OUT_REG      = 1'b0,
   localparam int unsigned POS_W       = $clog2(NUM_TAPS)
) (
   input  logic                clk_i,
   input  logic                rst_n_i,
   input  logic                cs_n_i,
   input  logic                inc_i,
   input  logic                dir_up_i,
   output logic [NUM_TAPS-1:0] tap_sel_o,
   output logic [POS_W-1:0]    position_o,
   output logic                store_busy_o,
   output logic                store_done_o,
   output logic                standby_o
);

   if (NUM_TAPS < 2) begin : g_bad_taps
      $error("wiper_pos_ctrl: NUM_TAPS must be at least 2");
   end
   if (NV_INIT >= NUM_TAPS) begin : g_bad_init
      $error("wiper_pos_ctrl: NV_INIT must be below NUM_TAPS");
   end
   if (STORE_CYCLES < 1) begin : g_bad_store
      $error("wiper_pos_ctrl: STORE_CYCLES must be at least 1");
   end

   pin_set_t         pins_raw, pins_s;
   logic             cs_n_d, inc_d;
   logic             cs_rise, inc_fall, step;
   logic [POS_W-1:0] nv_val, pos;

   assign pins_raw = '{cs_n: cs_n_i, inc: inc_i, up: dir_up_i};

   wpc_sync #(
      .STAGES   (SYNC_STAGES),
      .WIDTH    ($bits(pin_set_t)),
      .RESET_VAL(PINS_IDLE)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_n_i(rst_n_i),
      .din_i  (pins_raw),
      .dout_o (pins_s)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         cs_n_d <= 1'b1;
         inc_d  <= 1'b1;
      end else begin
         cs_n_d <= pins_s.cs_n;
         inc_d  <= pins_s.inc;
      end
   end

   assign cs_rise  = !cs_n_d & pins_s.cs_n;
   assign inc_fall = inc_d & !pins_s.inc;
   assign step     = inc_fall & !pins_s.cs_n;

   wpc_counter #(
      .NUM_TAPS(NUM_TAPS),
      .POS_W   (POS_W)
   ) u_count (
      .clk_i     (clk_i),
      .rst_n_i   (rst_n_i),
      .load_val_i(nv_val),
      .step_i    (step),
      .up_i      (pins_s.up),
      .pos_o     (pos)
   );

   wpc_store #(
      .POS_W       (POS_W),
      .STORE_CYCLES(STORE_CYCLES),
      .NV_INIT     (NV_INIT)
   ) u_store (
      .clk_i    (clk_i),
      .rst_n_i  (rst_n_i),
      .cs_n_s_i (pins_s.cs_n),
      .cs_rise_i(cs_rise),
      .inc_s_i  (pins_s.inc),
      .pos_i    (pos),
      .nv_val_o (nv_val),
      .busy_o   (store_busy_o),
      .done_o   (store_done_o),
      .standby_o(standby_o)
   );

   wpc_decode #(
      .NUM_TAPS(NUM_TAPS),
      .POS_W   (POS_W),
      .OUT_REG (OUT_REG)
   ) u_dec (
      .clk_i(clk_i),
      .pos_i(pos),
      .hot_o(tap_sel_o)
   );

   assign position_o = pos;

   AST_ONE_TAP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $countones(tap_sel_o) == 1); // R1
   AST_NOSTORE_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      cs_rise && !pins_s.inc && !store_busy_o |=> standby_o && !store_busy_o); // R6
   AST_SELECTED_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !pins_s.cs_n && !store_busy_o |=> !standby_o); // R7

endmodule

// File: tb/sim_wiper_pos_ctrl.sv
`timescale 1ns/1ps
module sim_wiper_pos_ctrl;

   localparam int TAPS   = 100;
   localparam int W      = 7;
   localparam int STORE  = 37;
   localparam int INIT   = 50;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cs_n = 1'b1;
   logic            inc = 1'b1;
   logic            up = 1'b0;
   logic [TAPS-1:0] tap_sel;
   logic [W-1:0]    position;
   logic            busy, done, standby;

   int n_chk = 0;
   int n_fail = 0;
   int exp_pos = INIT;
   int exp_nv = INIT;

   always #4 clk = ~clk;

   wiper_pos_ctrl #(
      .NUM_TAPS(TAPS), .SYNC_STAGES(2), .STORE_CYCLES(STORE),
      .NV_INIT(INIT), .OUT_REG(1'b0)
   ) u0 (
      .clk_i(clk), .rst_n_i(rst_n), .cs_n_i(cs_n), .inc_i(inc),
      .dir_up_i(up), .tap_sel_o(tap_sel), .position_o(position),
      .store_busy_o(busy), .store_done_o(done), .standby_o(standby)
   );

   function automatic int f_step(int p, bit dir);
      if (dir) return (p < TAPS - 1) ? p + 1 : p;
      return (p > 0) ? p - 1 : p;
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_pos(string req);
      logic [TAPS-1:0] want;
      want = {{(TAPS-1){1'b0}}, 1'b1} << exp_pos;
      check(req, int'(position), exp_pos);
      check({req, "/R1 one-hot"}, int'(tap_sel == want), 1);
   endtask

   // one strobe pulse; counts only while selected (R2, R3, R4)
   task automatic pulse(bit dir);
      up = dir; tick(3);
      inc = 1'b0; tick(5);
      if (!cs_n) exp_pos = f_step(exp_pos, dir);
      inc = 1'b1; tick(5);
   endtask

   task automatic select_blk();
      cs_n = 1'b0; tick(5);
      check("R7 awake when selected", int'(standby), 0);
   endtask

   // release with strobe high: store (R5, R7)
   task automatic release_store();
      int nb = 0, nd = 0, sb = 0;
      inc = 1'b1; cs_n = 1'b1;
      for (int k = 0; k < STORE + 20; k++) begin
         @(negedge clk);
         if (busy) nb++;
         if (done) nd++;
         if (busy && standby) sb++;
      end
      exp_nv = exp_pos;
      check("R5 busy length", nb, STORE);
      check("R5 done pulse", nd, 1);
      check("R7 no standby while storing", sb, 0);
      check("R7 standby after store", int'(standby), 1);
      check_pos("R5 position kept");
   endtask

   // final step with strobe left low, then release: no store (R6)
   task automatic step_release_nostore(bit dir);
      int nb = 0;
      up = dir; tick(3);
      inc = 1'b0; tick(5);
      exp_pos = f_step(exp_pos, dir);
      cs_n = 1'b1;
      for (int k = 0; k < STORE + 10; k++) begin
         @(negedge clk);
         if (busy) nb++;
      end
      check("R6 no busy", nb, 0);
      check("R6 standby", int'(standby), 1);
      check_pos("R6 position kept");
      inc = 1'b1; tick(5);
      check_pos("R2 strobe rise deselected");
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick(3);
      rst_n = 1'b1; tick(4);
      exp_pos = exp_nv;
      check_pos("R8 recall");
      check("R7 standby after reset", int'(standby), 1);
      check("R5 idle after reset", int'(busy), 0);
   endtask

   initial begin : watchdog
      repeat (150_000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h0005_EED5));
      tick(4);
      rst_n = 1'b1; tick(4);
      check_pos("R8 power-up value");
      check("R7 standby out of reset", int'(standby), 1);
      check("R5 not busy out of reset", int'(busy), 0);

      // R2: strobes ignored while deselected
      pulse(1'b1); pulse(1'b0);
      check_pos("R2 ignored deselected");

      // R3: direction changes while selected
      select_blk();
      pulse(1'b1); check_pos("R3 up");
      pulse(1'b1); check_pos("R3 up again");
      pulse(1'b0); check_pos("R3 down after change");

      // R4: top saturation
      while (exp_pos < TAPS - 1) pulse(1'b1);
      check_pos("R4 reach top");
      pulse(1'b1); check_pos("R4 hold top");
      check("R4 top index", int'(position), TAPS - 1);

      // R5 + R8: store top then reset
      release_store();
      do_reset();
      check("R8 recalled top", int'(position), TAPS - 1);

      // R4: bottom saturation
      select_blk();
      while (exp_pos > 0) pulse(1'b0);
      pulse(1'b0); check_pos("R4 hold bottom");
      check("R4 bottom index", int'(position), 0);

      // R6: no-store release, then reset recalls old stored value
      step_release_nostore(1'b1);
      do_reset();
      check("R8 no-store not recalled", int'(position), TAPS - 1);

      // random mix
      for (int it = 0; it < 160; it++) begin
         int op;
         op = int'($urandom_range(0, 11));
         if (op <= 6) begin
            if (cs_n) select_blk();
            pulse(1'($urandom_range(0, 1)));
            check_pos("R3 random step");
         end else if (op == 7) begin
            if (!cs_n) release_store();
            pulse(1'($urandom_range(0, 1)));
            check_pos("R2 random deselected strobe");
         end else if (op == 8) begin
            if (cs_n) select_blk();
            release_store();
         end else if (op == 9) begin
            if (cs_n) select_blk();
            step_release_nostore(1'($urandom_range(0, 1)));
         end else if (op == 10) begin
            if (!cs_n) step_release_nostore(1'b0);
            do_reset();
         end else begin
            if (cs_n) select_blk();
            for (int j = 0; j < 12; j++) pulse(1'($urandom_range(0, 3) != 0));
            check_pos("R4 random run");
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule